// File: doc/BRIEF.md
# Cache-Aligned DMA Burst Length Selector

This block picks the length of every burst a DMA master puts on a PCI-style bus. A transfer starts with a start strobe that loads a Dword start address and a Dword count. After that the block offers one burst at a time on a valid/ready handshake, with its length and Dword address. Each accepted burst moves the address forward and lowers the remaining count. When the count reaches zero the block raises a done flag.

The block reads two configuration values when the transfer starts: the programmed cache line size and the maximum DMA burst length. From them it derives an effective line size. It then steps toward a line boundary. It issues single Dwords until the address is 4-Dword aligned, then the largest power-of-two burst to which the address is aligned. Once the address is on a line boundary, it issues full-line bursts. No burst ever runs past the remaining data.

Top module: `dma_burst_sizer`

## Requirements
- R1: The cache line size value, in Dwords, is rounded down to a power of two between 2 and 128. Values of 128 or more give 128. The result is latched when start is high.
- R2: The effective line size is the smaller of the rounded line size and the maximum burst length, which is rounded down the same way.
- R3: A line size value below 2 (including 0) turns alignment off. Every burst is then the rounded maximum burst length, whatever the address.
- R4: A maximum burst length below 2 makes every burst a single Dword.
- R5: With alignment on and address bits [1:0] not zero, the offered burst length is 1.
- R6: With alignment on and the address 4-Dword aligned, the burst is the largest power of two that divides the address, capped at the effective line size.
- R7: Once the address sits on a boundary of the effective line size, every later burst of that transfer uses the effective line size.
- R8: No burst exceeds the remaining count. When the chosen size is too large, the burst shrinks to the largest power of two not above the remaining count.
- R9: burst_len and burst_addr hold while burst_valid is high and burst_ready is low. On acceptance the next burst address is the old address plus the old length.
- R10: start loads the address and count and overrides any burst in flight. done is high exactly when a loaded transfer has zero Dwords left, and burst_valid is low while done is high.
- R11: After reset, burst_valid and done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Loads a new transfer |
| start_addr | input | ADDR_W (30) | Dword start address |
| start_count | input | CNT_W (16) | Dwords to move |
| line_size_reg | input | 8 | Programmed cache line size in Dwords |
| max_burst | input | 8 | Maximum DMA burst length in Dwords |
| burst_valid | output | 1 | A burst is offered |
| burst_ready | input | 1 | The offered burst is taken |
| burst_len | output | 8 | Offered burst length in Dwords (power of two) |
| burst_addr | output | ADDR_W (30) | Dword address of the offered burst |
| done | output | 1 | The transfer has no Dwords left |

## Verification
Each transfer is run with the handshake always ready, and the whole sequence of lengths and addresses is compared with a list worked out by hand. An odd start address with a roomy count exercises the single-Dword, stepping, full-line and tail-shrink phases in one run. A line size that is not a power of two, combined with a smaller burst limit, separates rounding from taking the minimum. Line sizes of 0 and 1 tell the misaligned full bursts of the alignment-off mode apart from the single-Dword path used when the burst limit is below 2. A stalled handshake, a restart in mid-transfer and a zero-length transfer show the holding, override and done behaviour.

// File: rtl/bsel_pkg.sv
package bsel_pkg;

    localparam int LOG_MAX = 7;
    localparam int LG_W    = $clog2(LOG_MAX + 1);
    localparam int LEN_W   = LOG_MAX + 1;
    localparam int CFG_W   = 8;

    typedef logic [LG_W-1:0] lg_t;

    typedef struct packed {
        logic align_on;
        lg_t  eff_lg;
    } line_cfg_t;

    // floor(log2(v)), clipped to LOG_MAX; 0 and 1 both give 0
    function automatic lg_t floor_lg(input logic [31:0] v);
        lg_t r;
        r = '0;
        for (int i = 1; i <= LOG_MAX; i++) begin
            if (v >= (32'd1 << i)) r = lg_t'(i);
        end
        return r;
    endfunction

    function automatic lg_t min_lg(input lg_t a, input lg_t b);
        return (a < b) ? a : b;
    endfunction

    // count of trailing zero bits, capped at LOG_MAX
    function automatic lg_t trail_lg(input logic [31:0] a);
        lg_t r;
        r = lg_t'(LOG_MAX);
        for (int i = LOG_MAX - 1; i >= 0; i--) begin
            if (a[i]) r = lg_t'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/bsel_line_cfg.sv
module bsel_line_cfg
    import bsel_pkg::*;
(
    input  logic [CFG_W-1:0] line_reg,
    input  logic [CFG_W-1:0] max_reg,
    output line_cfg_t        cfg
);
    lg_t line_lg;
    lg_t max_lg;
    logic on;

    always_comb begin
        line_lg = floor_lg(32'(line_reg));
        max_lg  = floor_lg(32'(max_reg));
        on      = (line_reg >= CFG_W'(2));
        cfg.align_on = on;
        cfg.eff_lg   = on ? min_lg(line_lg, max_lg) : max_lg;
    end
endmodule

// File: rtl/bsel_size_pick.sv
module bsel_size_pick
    import bsel_pkg::*;
#(
    parameter int ADDR_W = 30,
    parameter int CNT_W  = 16
) (
    input  line_cfg_t         cfg,
    input  logic              in_line,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  rem,
    output lg_t               pick_lg,
    output logic              at_line
);
    lg_t  addr_tz;
    lg_t  rem_lg;
    lg_t  base_lg;
    logic quad_ok;

    always_comb begin
        addr_tz = trail_lg(32'(addr));
        rem_lg  = floor_lg(32'(rem));
        quad_ok = (addr[1:0] == 2'b00);
        at_line = quad_ok && (addr_tz >= cfg.eff_lg);
        if (!cfg.align_on || in_line || at_line)
            base_lg = cfg.eff_lg;
        else if (!quad_ok)
            base_lg = '0;
        else
            base_lg = min_lg(cfg.eff_lg, addr_tz);
        pick_lg = min_lg(base_lg, rem_lg);
    end
endmodule

// File: rtl/bsel_xfer_state.sv
module bsel_xfer_state
    import bsel_pkg::*;
#(
    parameter int ADDR_W = 30,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [CNT_W-1:0]  start_count,
    input  line_cfg_t         cfg_new,
    input  logic              accept,
    input  logic [LEN_W-1:0]  step_len,
    input  logic              at_line,
    output logic [ADDR_W-1:0] addr_q,
    output logic [CNT_W-1:0]  rem_q,
    output line_cfg_t         cfg_q,
    output logic              in_line_q,
    output logic              active_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q    <= '0;
            rem_q     <= '0;
            cfg_q     <= '0;
            in_line_q <= 1'b0;
            active_q  <= 1'b0;
        end else if (start) begin
            addr_q    <= start_addr;
            rem_q     <= start_count;
            cfg_q     <= cfg_new;
            in_line_q <= 1'b0;
            active_q  <= 1'b1;
        end else if (accept) begin
            addr_q <= addr_q + ADDR_W'(step_len);
            rem_q  <= rem_q - CNT_W'(step_len);
            if (at_line) in_line_q <= 1'b1;
        end
    end
endmodule

// File: rtl/dma_burst_sizer.sv
module dma_burst_sizer
    import bsel_pkg::*;
#(
    parameter int ADDR_W = 30,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [CNT_W-1:0]  start_count,
    input  logic [CFG_W-1:0]  line_size_reg,
    input  logic [CFG_W-1:0]  max_burst,
    output logic              burst_valid,
    input  logic              burst_ready,
    output logic [LEN_W-1:0]  burst_len,
    output logic [ADDR_W-1:0] burst_addr,
    output logic              done
);
    line_cfg_t         cfg_new;
    line_cfg_t         cfg_cur;
    logic [ADDR_W-1:0] addr_cur;
    logic [CNT_W-1:0]  rem_cnt;
    logic              in_line;
    logic              active;
    logic              at_line;
    lg_t               pick_lg;
    logic              accept;
    logic              align_live;

    bsel_line_cfg cfg_u (
        .line_reg (line_size_reg),
        .max_reg  (max_burst),
        .cfg      (cfg_new)
    );

    bsel_size_pick #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) pick_u (
        .cfg     (cfg_cur),
        .in_line (in_line),
        .addr    (addr_cur),
        .rem     (rem_cnt),
        .pick_lg (pick_lg),
        .at_line (at_line)
    );

    bsel_xfer_state #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) state_u (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .start_addr  (start_addr),
        .start_count (start_count),
        .cfg_new     (cfg_new),
        .accept      (accept),
        .step_len    (burst_len),
        .at_line     (at_line),
        .addr_q      (addr_cur),
        .rem_q       (rem_cnt),
        .cfg_q       (cfg_cur),
        .in_line_q   (in_line),
        .active_q    (active)
    );

    always_comb begin
        burst_valid = active && (rem_cnt != '0);
        done        = active && (rem_cnt == '0);
        burst_len   = LEN_W'(1) << pick_lg;
        burst_addr  = addr_cur;
        accept      = burst_valid && burst_ready;
        align_live  = cfg_cur.align_on;
    end
endmodule

// File: rtl/bsel_chk.sv
module bsel_chk
    import bsel_pkg::*;
#(
    parameter int ADDR_W = 30,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              burst_valid,
    input logic              burst_ready,
    input logic [LEN_W-1:0]  burst_len,
    input logic [ADDR_W-1:0] burst_addr,
    input logic              done,
    input logic [CNT_W-1:0]  rem_cnt,
    input logic              align_live
);
    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        burst_valid |-> (32'(burst_len) <= 32'(rem_cnt)));

    // R6
    len_pow2_chk: assert property (@(posedge clk) disable iff (rst)
        burst_valid |-> ($countones(burst_len) == 1));

    // R5
    misalign_single_chk: assert property (@(posedge clk) disable iff (rst)
        (burst_valid && align_live && (burst_addr[1:0] != 2'b00)) |-> (burst_len == LEN_W'(1)));

    // R6
    aligned_burst_chk: assert property (@(posedge clk) disable iff (rst)
        (burst_valid && align_live) |-> ((burst_addr & (ADDR_W'(burst_len) - ADDR_W'(1))) == '0));

    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (burst_valid && !burst_ready && !start) |=>
            (burst_valid && $stable(burst_len) && $stable(burst_addr)));

    // R9
    advance_chk: assert property (@(posedge clk) disable iff (rst)
        (burst_valid && burst_ready && !start) |=>
            (burst_addr == $past(burst_addr) + ADDR_W'($past(burst_len))));

    // R10
    done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !burst_valid);
endmodule

bind dma_burst_sizer bsel_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .burst_valid (burst_valid),
    .burst_ready (burst_ready),
    .burst_len   (burst_len),
    .burst_addr  (burst_addr),
    .done        (done),
    .rem_cnt     (rem_cnt),
    .align_live  (align_live)
);

// File: tb/dma_burst_sizer_tb_top.sv
module dma_burst_sizer_tb_top;
    localparam int ADDR_W = 30;
    localparam int CNT_W  = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic [ADDR_W-1:0] start_addr = '0;
    logic [CNT_W-1:0]  start_count = '0;
    logic [7:0]        line_size_reg = '0;
    logic [7:0]        max_burst = '0;
    logic              burst_valid;
    logic              burst_ready = 1'b0;
    logic [7:0]        burst_len;
    logic [ADDR_W-1:0] burst_addr;
    logic              done;

    int n_chk = 0;
    int n_err = 0;
    int e_len[$];
    int e_adr[$];

    always #4 clk = ~clk;

    dma_burst_sizer #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
        .start_count(start_count), .line_size_reg(line_size_reg),
        .max_burst(max_burst), .burst_valid(burst_valid),
        .burst_ready(burst_ready), .burst_len(burst_len),
        .burst_addr(burst_addr), .done(done)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic load(input int a, input int c, input int cls, input int mb);
        @(negedge clk);
        start         = 1'b1;
        start_addr    = ADDR_W'(a);
        start_count   = CNT_W'(c);
        line_size_reg = 8'(cls);
        max_burst     = 8'(mb);
        @(negedge clk);
        start = 1'b0;
    endtask

    // runs a transfer with ready held high, compares against e_len/e_adr
    task automatic run_xfer(input string req, input int a, input int c,
                            input int cls, input int mb);
        int idx;
        burst_ready = 1'b1;
        load(a, c, cls, mb);
        idx = 0;
        for (int g = 0; g < 1000 && !done; g++) begin
            if (burst_valid) begin
                if (idx < e_len.size()) begin
                    chk({req, " len"}, int'(burst_len), e_len[idx]);
                    chk({req, " addr"}, int'(burst_addr), e_adr[idx]);
                end
                idx++;
            end
            @(negedge clk);
        end
        chk({req, " burst count"}, idx, e_len.size());
        chk({req, " done"}, int'(done), 1);
        chk({req, " valid after done"}, int'(burst_valid), 0);
        burst_ready = 1'b0;
    endtask

    task automatic t_reset();
        // R11
        chk("R11 valid", int'(burst_valid), 0);
        chk("R11 done", int'(done), 0);
    endtask

    task automatic t_stepping();
        // R5 R6 R7 R8: odd start, line 32, limit 128
        e_len = '{1, 4, 8, 16, 32, 32, 4, 2, 1};
        e_adr = '{3, 4, 8, 16, 32, 64, 96, 100, 102};
        run_xfer("R6 R7 stepping", 3, 100, 32, 128);
    endtask

    task automatic t_min_rule();
        // R1 R2: 48 rounds to 32, limit 16 wins
        e_len = '{1, 1, 4, 8, 16, 8, 2};
        e_adr = '{2, 3, 4, 8, 16, 32, 40};
        run_xfer("R2 min line/limit", 2, 40, 48, 16);
    endtask

    task automatic t_big_line();
        // R1: 200 rounds to 128
        e_len = '{128, 128, 32, 8, 4};
        e_adr = '{0, 128, 256, 288, 296};
        run_xfer("R1 round to 128", 0, 300, 200, 255);
    endtask

    task automatic t_align_off();
        // R3: line size 1 and 0 disable alignment
        e_len = '{8, 8, 4};
        e_adr = '{5, 13, 21};
        run_xfer("R3 line one", 5, 20, 1, 8);
        e_len = '{4, 2};
        e_adr = '{1, 5};
        run_xfer("R3 line zero", 1, 6, 0, 4);
    endtask

    task automatic t_tiny_limit();
        // R4
        e_len = '{1, 1, 1};
        e_adr = '{0, 1, 2};
        run_xfer("R4 single", 0, 3, 16, 1);
    endtask

    task automatic t_stall_restart();
        // R9 R10
        burst_ready = 1'b0;
        load(8, 20, 16, 16);
        for (int k = 0; k < 3; k++) begin
            chk("R9 hold valid", int'(burst_valid), 1);
            chk("R9 hold len", int'(burst_len), 8);
            chk("R9 hold addr", int'(burst_addr), 8);
            @(negedge clk);
        end
        burst_ready = 1'b1;
        @(negedge clk);
        burst_ready = 1'b0;
        chk("R9 advance addr", int'(burst_addr), 16);
        chk("R8 shrink len", int'(burst_len), 8);
        @(negedge clk);
        chk("R9 still held", int'(burst_addr), 16);
        load(0, 2, 16, 16);
        chk("R10 restart addr", int'(burst_addr), 0);
        chk("R10 restart len", int'(burst_len), 2);
        chk("R10 restart done", int'(done), 0);
        load(7, 0, 16, 16);
        chk("R10 zero count done", int'(done), 1);
        chk("R10 zero count valid", int'(burst_valid), 0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_stepping();
        t_min_rule();
        t_big_line();
        t_align_off();
        t_tiny_limit();
        t_stall_restart();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule